// File: doc/BRIEF.md
# Prime-Bank Modulo Address Mapper

This block turns a flat word address into a bank number and a word offset inside that bank, for a memory built from a prime number of banks that each hold a power-of-two number of words. Sequential interleaving would pick the bank by dividing the address. Here the bank is instead the residue of the address modulo the bank count, and the offset is the residue modulo the bank size. Because the two moduli are co-prime, every address below their product lands on its own (bank, offset) pair, and no divider is needed anywhere.

A requester presents an address with a valid strobe. One clock later the block presents the bank, the offset and an error flag with its own valid strobe. A new address may be presented on every cycle. An address at or above the mapped range gives no mapping: it raises the error flag and returns zero for both fields.

Top module: `modint_bank_mapper`

## Requirements
- R1: After reset `out_valid` is 0, and it stays 0 until the first cycle that follows an accepted address.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle, which gives exactly one cycle of latency.
- R3: For an in-range address A, `out_bank` equals A mod NUM_BANKS. With 3 banks of 8 words, addresses 0, 16 and 8 give banks 0, 1 and 2, address 9 gives bank 0, and address 23 gives bank 2.
- R4: For an in-range address A, `out_offset` equals A mod 2^OFF_BITS, which is the low OFF_BITS bits of A. With the defaults, addresses 0, 16 and 8 give offset 0, address 9 gives offset 1, and address 23 gives offset 7.
- R5: An address A with A >= NUM_BANKS * 2^OFF_BITS (24 with the defaults) gives `out_err` = 1 together with `out_bank` = 0 and `out_offset` = 0. An in-range address gives `out_err` = 0.
- R6: The mapping is one-to-one: the addresses 0 to NUM_BANKS * 2^OFF_BITS - 1 produce pairwise distinct (bank, offset) pairs.
- R7: Addresses presented on consecutive cycles are each mapped, in order, with no lost or repeated result.
- R8: In a cycle with `in_valid` = 0, `in_addr` is ignored: in the next cycle `out_bank`, `out_offset` and `out_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | ADDR_BITS | Flat word address |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_bank | output | clog2(NUM_BANKS) | Bank number |
| out_offset | output | OFF_BITS | Word offset within the bank |
| out_err | output | 1 | Address outside the mapped range |

## Verification
The mapping of a fresh address and the holding of the previous result can meet at one register. An idle cycle that carries a changing address must leave the outputs alone, and a valid address in the very next cycle must overwrite them. The bench provokes this by interleaving idle cycles that carry random out-of-range and in-range addresses with back-to-back valid ones. Its model predicts, cycle by cycle, whether the outputs hold or load. The in-range/out-of-range boundary at 23 and 24 is crossed inside one back-to-back burst, so that the error path and the mapping path follow each other directly.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  // Smallest digit width d for which 2^d == 1 (mod n); digits of that
  // width sum to a value congruent to the whole address modulo n.
  function automatic int unsigned digit_width(input int unsigned n);
    int unsigned d;
    d = 1;
    for (int unsigned k = 1; k <= 16; k++) begin
      if (((64'd1 << k) % n) == 1 && d == 1 && ((64'd2 % n) != 1)) d = k;
    end
    if ((64'd2 % n) == 1) d = 1;
    return d;
  endfunction

  // Restoring reduction of a small digit sum; bounded compare-subtract steps.
  function automatic int unsigned reduce_mod(input int unsigned s,
                                             input int unsigned n);
    int unsigned r;
    r = s;
    for (int k = 15; k >= 0; k--) begin
      if (r >= (n << k)) r = r - (n << k);
    end
    return r;
  endfunction

endpackage

// File: rtl/bankmap_residue.sv
module bankmap_residue
  import bankmap_pkg::*;
#(
  parameter int ADDR_BITS = 5,
  parameter int NUM_BANKS = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_BITS-1:0] addr,
  output logic [BANK_W-1:0]    residue
);
  localparam int DW    = int'(digit_width(NUM_BANKS));
  localparam int NDIG  = (ADDR_BITS + DW - 1) / DW;
  localparam int PAD_W = NDIG * DW;
  localparam int SUM_W = DW + $clog2(NDIG + 1);

  logic [PAD_W-1:0] padded;
  logic [DW-1:0]    digit [NDIG];
  logic [SUM_W-1:0] digit_sum;

  assign padded = PAD_W'(addr);

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    assign digit[g] = padded[g*DW +: DW];
  end

  always_comb begin
    digit_sum = '0;
    for (int i = 0; i < NDIG; i++) digit_sum = digit_sum + SUM_W'(digit[i]);
  end

  assign residue = BANK_W'(reduce_mod(32'(digit_sum), NUM_BANKS));

endmodule

// File: rtl/bankmap_range.sv
module bankmap_range #(
  parameter int ADDR_BITS = 5,
  parameter int NUM_BANKS = 3,
  parameter int OFF_BITS  = 3
) (
  input  logic [ADDR_BITS-1:0] addr,
  output logic                 in_range
);
  localparam longint unsigned LIMIT = longint'(NUM_BANKS) << OFF_BITS;

  assign in_range = (64'(addr) < 64'(LIMIT));

endmodule

// File: rtl/modint_bank_mapper.sv
module modint_bank_mapper #(
  parameter int ADDR_BITS = 5,
  parameter int NUM_BANKS = 3,
  parameter int OFF_BITS  = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ADDR_BITS-1:0] in_addr,
  output logic                 out_valid,
  output logic [BANK_W-1:0]    out_bank,
  output logic [OFF_BITS-1:0]  out_offset,
  output logic                 out_err
);
  // Named internal events
  logic                in_range;
  logic [BANK_W-1:0]   map_bank;
  logic [OFF_BITS-1:0] map_offset;
  logic                load_map;
  logic                load_err;

  bankmap_residue #(.ADDR_BITS(ADDR_BITS), .NUM_BANKS(NUM_BANKS)) u_residue (
    .addr    (in_addr),
    .residue (map_bank)
  );

  bankmap_range #(.ADDR_BITS(ADDR_BITS), .NUM_BANKS(NUM_BANKS),
                  .OFF_BITS(OFF_BITS)) u_range (
    .addr     (in_addr),
    .in_range (in_range)
  );

  assign map_offset = in_addr[OFF_BITS-1:0];
  assign load_map   = in_valid &&  in_range;
  assign load_err   = in_valid && !in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bank   <= '0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_map) begin
        out_bank   <= map_bank;
        out_offset <= map_offset;
        out_err    <= 1'b0;
      end else if (load_err) begin
        out_bank   <= '0;
        out_offset <= '0;
        out_err    <= 1'b1;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_bank_below_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> 32'(out_bank) < NUM_BANKS);
  a_r4_offset_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    load_map |=> out_offset == $past(in_addr[OFF_BITS-1:0]));
  a_r5_err_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_bank == '0 && out_offset == '0);
  a_r5_err_on_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_err == !$past(in_range));
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bank) && $stable(out_offset) && $stable(out_err));

endmodule

// File: tb/modint_bank_mapper_tb.sv
module modint_bank_mapper_tb;
  localparam int AW = 5;
  localparam int NB = 3;
  localparam int OB = 3;
  localparam int SPAN = NB * (1 << OB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic [1:0]    out_bank;
  logic [OB-1:0] out_offset;
  logic          out_err;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int m_bank = 0, m_off = 0, m_err = 0;
  bit seen [SPAN];
  int pair_owner [NB * (1 << OB)];

  always #4 clk = ~clk;

  modint_bank_mapper #(.ADDR_BITS(AW), .NUM_BANKS(NB), .OFF_BITS(OB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_bank(out_bank), .out_offset(out_offset),
    .out_err(out_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check the registered result one
  // full cycle later at the next falling edge.
  task automatic step(input bit v, input int a, input string tag);
    in_valid = v;
    in_addr  = AW'(a);
    @(negedge clk);
    if (v) begin
      if (a >= SPAN) begin m_bank = 0; m_off = 0; m_err = 1; end
      else begin m_bank = a % NB; m_off = a % (1 << OB); m_err = 0; end
      chk({tag, " R2 valid"}, int'(out_valid), 1);
      chk({tag, " R3 bank"}, int'(out_bank), m_bank);
      chk({tag, " R4 offset"}, int'(out_offset), m_off);
      chk({tag, " R5 err"}, int'(out_err), m_err);
      if (a < SPAN) begin
        int key = int'(out_bank) * (1 << OB) + int'(out_offset);
        seen[a] = 1;
        if (pair_owner[key] >= 0 && pair_owner[key] != a)
          chk("R6 distinct pair", pair_owner[key], a);
        pair_owner[key] = a;
      end
    end else begin
      chk({tag, " R2 idle"}, int'(out_valid), 0);
      chk({tag, " R8 bank held"}, int'(out_bank), m_bank);
      chk({tag, " R8 offset held"}, int'(out_offset), m_off);
      chk({tag, " R8 err held"}, int'(out_err), m_err);
    end
  endtask

  initial begin
    for (int i = 0; i < NB * (1 << OB); i++) pair_owner[i] = -1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", int'(out_valid), 0);
    // worked examples
    step(1, 0, "R3 ex0");
    step(1, 16, "R3 ex16");
    step(1, 8, "R3 ex8");
    step(1, 9, "R4 ex9");
    step(1, 23, "R4 ex23");
    // back-to-back sweep across the range edge
    for (int a = 0; a < (1 << AW); a++) step(1, a, "R7 sweep");
    // idle cycles carrying changing addresses, then loads
    for (int k = 0; k < 40; k++) begin
      int a = $urandom_range((1 << AW) - 1);
      step(0, $urandom_range((1 << AW) - 1), "R8 gap");
      step(0, 24 + (k % 8), "R8 gap oor");
      step(1, a, "R7 after gap");
      step(1, (a + 11) % (1 << AW), "R7 burst");
    end
    step(1, 30, "R5 oor");
    step(0, 5, "R8 after err");
    step(1, 23, "R5 edge in");
    step(1, 24, "R5 edge out");
    begin
      int cnt = 0;
      for (int a = 0; a < SPAN; a++) cnt += int'(seen[a]);
      chk("R6 all mapped", cnt, SPAN);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R7: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule